// File: doc/BRIEF.md
# XOR-Indexed Single-Enable Line Store

This block is a small store of cache lines. Each entry holds a valid flag, a tag and one line of data. Every request selects one entry through a fixed index function. The function drops the byte-offset bits of the address, shifts the resulting line address right by a configurable amount, XORs the result with the constant (entry count minus one) and keeps the low index bits. Only the selected entry is enabled for the access, and every other entry stays idle. No tag is compared in parallel across entries, and no replacement choice is made.

A request arrives on a valid/ready handshake that carries a byte address and a fill line. If the selected entry is valid and its tag equals the full line address, the access is a hit: the stored line is returned and the hit counter advances. Any other result is a miss: the fill line and the new tag overwrite the selected entry, the fill line is returned, and the miss counter advances. Both counters saturate.

The control is a four-state machine:
- IDLE holds ready high and takes a request (IDLE to INDEX).
- INDEX registers the index (INDEX to ACCESS).
- ACCESS raises the single entry enable, compares, updates the entry and registers the response (ACCESS to DONE).
- DONE presents the response for one cycle (DONE to IDLE).

Top module: `xls_store`

## Requirements
- R1: A synchronous reset clears every entry's valid flag and both counters. After reset, req_ready is 1, and entry_en, rsp_valid, rsp_hit and rsp_miss are 0. The first lookup of any address after reset is a miss.
- R2: The selected entry index equals the low log2(ENTRIES) bits of ((addr >> log2(LINE_BYTES)) >> SHIFT_X) XOR (ENTRIES-1). Bit k of entry_en corresponds to entry k. With ENTRIES=4, LINE_BYTES=1 and SHIFT_X=1, addresses 100, 101, 104, 123 and 140 select entries 1, 1, 3, 2 and 1.
- R3: entry_en is one-hot during the ACCESS cycle and all zero in every other cycle.
- R4: req_ready is 1 only in IDLE. A request is accepted on a clock edge where req_valid and req_ready are both 1. req_valid held high while the block is busy has no effect: it produces no extra response and no counter change.
- R5: A hit occurs when the selected entry is valid and its stored tag equals the full line address. On a hit, rsp_hit=1, rsp_miss=0, rsp_data is the stored line, hit_count rises by one and the entry is left unchanged.
- R6: On a miss, the selected entry takes the new tag and the fill line and becomes valid. The response shows rsp_miss=1, rsp_hit=0 and rsp_data equal to the fill line, and miss_count rises by one.
- R7: With the accept edge counted as edge 0, entry_en is active in the cycle after edge 1. rsp_valid is high for exactly one cycle, the cycle after edge 2, and is low in every other cycle.
- R8: hit_count and miss_count stop at 2^CNT_W-1 and never wrap.
- R9: A fill changes only the selected entry. Lines held in the other entries still hit afterwards with their original data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_fill | input | LINE_BYTES*8 | Line written on a miss |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_data | output | LINE_BYTES*8 | Stored line on a hit, fill line on a miss |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| entry_en | output | ENTRIES | Per-entry enable, one-hot during access |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The bench builds the block with ENTRIES=4, LINE_BYTES=1, SHIFT_X=1, ADDR_W=16 and CNT_W=4. With a one-byte line and a one-bit shift, the index function acts on the raw address, so the five-address example above can be checked directly against entry_en. It also makes it easy to pick addresses that collide on an entry while carrying different tags. The 4-bit counters let the bench reach saturation at 15 within a few dozen requests. Repeated misses on one entry drive the miss counter to its limit, and repeated hits drive the hit counter to its limit.

// File: rtl/xls_pkg.sv
package xls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_ACCESS,
        ST_DONE
    } xls_state_t;

endpackage

// File: rtl/xls_index.sv
// Index function: shift the line address right, XOR with (ENTRIES-1), keep low bits.
module xls_index #(
    parameter int TAG_W   = 27,
    parameter int IDX_W   = 3,
    parameter int SHIFT_X = 14,
    parameter int ENTRIES = 8
) (
    input  logic [TAG_W-1:0] line_addr,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] XOR_MASK = IDX_W'(ENTRIES - 1);

    logic [TAG_W-1:0] shifted;

    assign shifted = line_addr >> SHIFT_X;
    assign idx     = IDX_W'(shifted) ^ XOR_MASK;

endmodule

// File: rtl/xls_line_entry.sv
// One storage entry; outputs are forced to zero unless enabled so an OR mux can combine them.
module xls_line_entry #(
    parameter int TAG_W  = 27,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [LINE_W-1:0] line_in,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [LINE_W-1:0] out_line
);

    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (en && wr) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (en && wr) begin
            tag_q  <= tag_in;
            line_q <= line_in;
        end
    end

    assign out_valid = en && valid_q;
    assign out_tag   = en ? tag_q  : '0;
    assign out_line  = en ? line_q : '0;

endmodule

// File: rtl/xls_sat_counter.sv
module xls_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/xls_ctrl.sv
module xls_ctrl
    import xls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic cap_req,
    output logic idx_load,
    output logic access,
    output logic rsp_valid
);

    xls_state_t state_q;
    xls_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_INDEX;
            ST_INDEX:  state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        cap_req   = 1'b0;
        idx_load  = 1'b0;
        access    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cap_req   = req_valid;
            end
            ST_INDEX:  idx_load  = 1'b1;
            ST_ACCESS: access    = 1'b1;
            ST_DONE:   rsp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/xls_store.sv
module xls_store
    import xls_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int ENTRIES    = 8,
    parameter int SHIFT_X    = 14,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LINE_BYTES*8-1:0] req_fill,
    output logic                    rsp_valid,
    output logic [LINE_BYTES*8-1:0] rsp_data,
    output logic                    rsp_hit,
    output logic                    rsp_miss,
    output logic [ENTRIES-1:0]      entry_en,
    output logic [CNT_W-1:0]        hit_count,
    output logic [CNT_W-1:0]        miss_count
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int LINE_W = LINE_BYTES * 8;

    logic              cap_req;
    logic              idx_load;
    logic              access;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] fill_q;
    logic [IDX_W-1:0]  idx_d;
    logic [IDX_W-1:0]  idx_q;

    generate
        if (OFF_W > 0) begin : g_offset
            logic unused_offset;
            assign unused_offset = ^req_addr[OFF_W-1:0];
        end
    endgenerate

    xls_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .cap_req   (cap_req),
        .idx_load  (idx_load),
        .access    (access),
        .rsp_valid (rsp_valid)
    );

    always_ff @(posedge clk) begin
        if (cap_req) begin
            tag_q  <= req_addr[ADDR_W-1:OFF_W];
            fill_q <= req_fill;
        end
    end

    xls_index #(
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W),
        .SHIFT_X (SHIFT_X),
        .ENTRIES (ENTRIES)
    ) u_index (
        .line_addr (tag_q),
        .idx       (idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_load) begin
            idx_q <= idx_d;
        end
    end

    logic              e_valid [ENTRIES];
    logic [TAG_W-1:0]  e_tag   [ENTRIES];
    logic [LINE_W-1:0] e_line  [ENTRIES];
    logic              wr_now;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            assign entry_en[g] = access && (idx_q == IDX_W'(g));

            xls_line_entry #(
                .TAG_W  (TAG_W),
                .LINE_W (LINE_W)
            ) u_entry (
                .clk       (clk),
                .rst       (rst),
                .en        (entry_en[g]),
                .wr        (wr_now),
                .tag_in    (tag_q),
                .line_in   (fill_q),
                .out_valid (e_valid[g]),
                .out_tag   (e_tag[g]),
                .out_line  (e_line[g])
            );
        end
    endgenerate

    logic              sel_valid;
    logic [TAG_W-1:0]  sel_tag;
    logic [LINE_W-1:0] sel_line;
    logic              hit_now;

    always_comb begin
        sel_valid = 1'b0;
        sel_tag   = '0;
        sel_line  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_valid = sel_valid | e_valid[i];
            sel_tag   = sel_tag   | e_tag[i];
            sel_line  = sel_line  | e_line[i];
        end
    end

    assign hit_now = sel_valid && (sel_tag == tag_q);
    assign wr_now  = access && !hit_now;

    logic              rsp_hit_q;
    logic [LINE_W-1:0] rsp_line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit_q  <= 1'b0;
            rsp_line_q <= '0;
        end else if (access) begin
            rsp_hit_q  <= hit_now;
            rsp_line_q <= hit_now ? sel_line : fill_q;
        end
    end

    assign rsp_hit  = rsp_valid && rsp_hit_q;
    assign rsp_miss = rsp_valid && !rsp_hit_q;
    assign rsp_data = rsp_line_q;

    xls_sat_counter #(.W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (access && hit_now),
        .count (hit_count)
    );

    xls_sat_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (wr_now),
        .count (miss_count)
    );

endmodule

// File: rtl/xls_store_chk.sv
module xls_store_chk #(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic [ENTRIES-1:0] entry_en,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    // R3
    onehot_en_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(entry_en));

    // R7
    en_then_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_en != '0) |=> rsp_valid);

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R5 R6
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    hit_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_count == CMAX) |=> (hit_count == CMAX));

    // R8
    miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_count == CMAX) |=> (miss_count == CMAX));

endmodule

bind xls_store xls_store_chk #(
    .ENTRIES (ENTRIES),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .entry_en   (entry_en),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/xls_store_test.sv
`timescale 1ns/1ps
module xls_store_test;

    localparam int AW = 16;
    localparam int LB = 1;
    localparam int N  = 4;
    localparam int X  = 1;
    localparam int CW = 4;
    localparam int LW = LB * 8;
    localparam int CMAX = 15;

    logic          clk;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_fill;
    logic          rsp_valid;
    logic [LW-1:0] rsp_data;
    logic          rsp_hit;
    logic          rsp_miss;
    logic [N-1:0]  entry_en;
    logic [CW-1:0] hit_count;
    logic [CW-1:0] miss_count;

    xls_store #(
        .ADDR_W     (AW),
        .LINE_BYTES (LB),
        .ENTRIES    (N),
        .SHIFT_X    (X),
        .CNT_W      (CW)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_fill   (req_fill),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_hit    (rsp_hit),
        .rsp_miss   (rsp_miss),
        .entry_en   (entry_en),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_hits = 0;
    int exp_miss = 0;

    // {addr[16], fill[8], entry[2], hit[1], data[8]}
    localparam logic [34:0] TBL [14] = '{
        {16'd100, 8'h11, 2'd1, 1'b0, 8'h11},
        {16'd101, 8'h22, 2'd1, 1'b0, 8'h22},
        {16'd104, 8'h33, 2'd3, 1'b0, 8'h33},
        {16'd123, 8'h44, 2'd2, 1'b0, 8'h44},
        {16'd140, 8'h55, 2'd1, 1'b0, 8'h55},
        {16'd104, 8'h66, 2'd3, 1'b1, 8'h33},
        {16'd123, 8'h77, 2'd2, 1'b1, 8'h44},
        {16'd140, 8'h88, 2'd1, 1'b1, 8'h55},
        {16'd100, 8'h99, 2'd1, 1'b0, 8'h99},
        {16'd140, 8'hAA, 2'd1, 1'b0, 8'hAA},
        {16'd6,   8'hBB, 2'd0, 1'b0, 8'hBB},
        {16'd6,   8'hCC, 2'd0, 1'b1, 8'hBB},
        {16'd100, 8'hDD, 2'd1, 1'b0, 8'hDD},
        {16'd104, 8'hEE, 2'd3, 1'b1, 8'h33}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bump(input bit hit);
        if (hit) begin
            if (exp_hits < CMAX) exp_hits++;
        end else begin
            if (exp_miss < CMAX) exp_miss++;
        end
    endtask

    // One request; samples the three negedges after the accept edge.
    task automatic run(input logic [AW-1:0] a, input logic [LW-1:0] f,
                       output logic [N-1:0] en1, output logic v1,
                       output logic [N-1:0] en2, output logic v2,
                       output logic v3, output logic h3, output logic m3,
                       output logic [LW-1:0] d3);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_fill  = f;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        en1 = entry_en;
        v1  = rsp_valid;
        @(negedge clk);
        en2 = entry_en;
        v2  = rsp_valid;
        @(negedge clk);
        v3 = rsp_valid;
        h3 = rsp_hit;
        m3 = rsp_miss;
        d3 = rsp_data;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [LW-1:0] f,
                          input int exp_idx, input bit exp_hit,
                          input logic [LW-1:0] exp_data, input string req);
        logic [N-1:0]  en1, en2;
        logic          v1, v2, v3, h3, m3;
        logic [LW-1:0] d3;
        run(a, f, en1, v1, en2, v2, v3, h3, m3, d3);
        if (exp_idx >= 0) check("R2", "entry_en", int'(en2), 1 << exp_idx);
        check("R3", "entry_en outside access", int'(en1), 0);
        check("R7", "rsp_valid early", int'(v1 | v2), 0);
        check("R7", "rsp_valid", int'(v3), 1);
        check(req, "rsp_hit", int'(h3), int'(exp_hit));
        check(req, "rsp_miss", int'(m3), int'(!exp_hit));
        check(req, "rsp_data", int'(d3), int'(exp_data));
        bump(exp_hit);
        check("R8", "hit_count", int'(hit_count), exp_hits);
        check("R8", "miss_count", int'(miss_count), exp_miss);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = '0;
        req_fill  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "req_ready", int'(req_ready), 1);
        check("R1", "entry_en", int'(entry_en), 0);
        check("R1", "rsp_valid", int'(rsp_valid | rsp_hit | rsp_miss), 0);
        check("R1", "hit_count", int'(hit_count), 0);
        check("R1", "miss_count", int'(miss_count), 0);

        // Table walk: R2 index example, R5 hits, R6 fills, R9 isolation
        for (int i = 0; i < 14; i++) begin
            lookup(TBL[i][34:19], TBL[i][18:11], int'(TBL[i][10:9]),
                   TBL[i][8], TBL[i][7:0], TBL[i][8] ? "R5" : "R6");
        end
        // R9: entry 3 kept 8'h33 across fills of entries 0 and 1 (last row)
        check("R9", "hits after foreign fills", int'(hit_count), 5);

        // R4: req_valid held high while busy has no effect
        begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 16'd6;
            req_fill  = 8'h01;
            @(posedge clk);
            @(negedge clk);
            req_addr = 16'd104;
            check("R4", "ready busy 1", int'(req_ready), 0);
            @(negedge clk);
            check("R4", "ready busy 2", int'(req_ready), 0);
            @(negedge clk);
            check("R4", "ready busy 3", int'(req_ready), 0);
            check("R5", "held request hit", int'(rsp_hit), 1);
            check("R5", "held request data", int'(rsp_data), 8'hBB);
            req_valid = 1'b0;
            bump(1'b1);
            @(negedge clk);
            check("R4", "ready back", int'(req_ready), 1);
            check("R4", "no extra rsp", int'(rsp_valid), 0);
            repeat (4) @(negedge clk);
            check("R4", "hit_count", int'(hit_count), exp_hits);
            check("R4", "miss_count", int'(miss_count), exp_miss);
        end
        lookup(16'd104, 8'h02, 3, 1'b1, 8'h33, "R9");

        // R8: miss counter saturation by alternating colliding tags
        for (int k = 0; k < 8; k++) begin
            lookup((k % 2 == 0) ? 16'd101 : 16'd100, 8'(8'h40 + k), 1, 1'b0,
                   8'(8'h40 + k), "R8");
        end
        check("R8", "miss saturated", int'(miss_count), CMAX);

        // R8: hit counter saturation
        for (int k = 0; k < 12; k++) begin
            lookup(16'd6, 8'h00, 0, 1'b1, 8'hBB, "R8");
        end
        check("R8", "hit saturated", int'(hit_count), CMAX);

        // R1: reset mid-run clears valid flags and counters
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_hits = 0;
        exp_miss = 0;
        check("R1", "hit_count after reset", int'(hit_count), 0);
        check("R1", "miss_count after reset", int'(miss_count), 0);
        check("R1", "ready after reset", int'(req_ready), 1);
        lookup(16'd104, 8'h5C, 3, 1'b0, 8'h5C, "R1");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule